// File: doc/BRIEF.md
# Phase-Step Monitor with Feedback Edge Reselection

This block sits beside the phase comparator of a clock-translation loop. It is driven by a fast sampling clock that runs at the oscillator rate, and it receives single-cycle marks for each edge of the divided reference clock and of the divided feedback clock. It counts sampling cycles between a reference mark and the next feedback mark, which gives a signed phase error. That error goes to a controller with hysteresis. The controller requests a narrow loop bandwidth when a large phase step appears, and it returns to the normal wide bandwidth once the error has settled.

When the reselection enable is high, the event that enters narrow mode also moves the feedback divider phase by the measured error. The new offset is taken modulo the divide ratio, so the feedback edge lands on the oscillator edge nearest the new reference phase. The step is absorbed at once and the loop does not have to slew through it. The offset can be loaded only once per excursion into narrow mode. If an edge arrives and its partner does not follow within one divided period, the block raises a missing-edge status and leaves the error unchanged.

Top module: `phase_step_monitor`

## Requirements
- R1: While reset is held, and after it is released, narrow_bw, fb_phase_ofs, err_value, err_valid and edge_missing all read zero.
- R2: When the partner edge arrives k sampling cycles after the first edge (0 <= k <= DIV_RATIO-1), err_value becomes +k if the reference edge came first and -k if the feedback edge came first. err_valid pulses for one cycle, starting on the clock edge that samples the closing edge. Edges in the same cycle give 0.
- R3: In wide mode, a measurement with magnitude strictly greater than TRIG_THR sets narrow_bw one clock after its err_valid pulse.
- R4: In wide mode, a measurement with magnitude at or below TRIG_THR (for example steady-lock errors of 0 or ±1) leaves narrow_bw low.
- R5: In narrow mode, a measurement with magnitude at or below REL_THR clears narrow_bw one clock after err_valid. Any larger measurement, including one above TRIG_THR, keeps narrow_bw high.
- R6: If reselect_en is low on the entry into narrow mode, fb_phase_ofs keeps its value.
- R7: If reselect_en is high on the entry into narrow mode, fb_phase_ofs becomes (fb_phase_ofs + err_value) mod DIV_RATIO, in the range 0 to DIV_RATIO-1. It updates on the same clock as narrow_bw.
- R8: While narrow_bw is high, further measurements do not change fb_phase_ofs, whatever their size.
- R9: If no partner edge arrives within DIV_RATIO-1 cycles of the first edge, edge_missing goes high, no err_valid pulse occurs and err_value is unchanged. The next valid measurement clears edge_missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_edge | input | 1 | One-cycle mark of a divided reference clock edge |
| fb_edge | input | 1 | One-cycle mark of a divided feedback clock edge |
| reselect_en | input | 1 | Enables feedback edge reselection on a phase step |
| narrow_bw | output | 1 | High while the narrow loop bandwidth is requested |
| fb_phase_ofs | output | $clog2(DIV_RATIO) | Feedback divider phase offset in sampling cycles |
| err_value | output | $clog2(DIV_RATIO)+1 | Last signed phase error, in sampling cycles |
| err_valid | output | 1 | One-cycle pulse when err_value has been updated |
| edge_missing | output | 1 | Partner edge did not arrive within one divided period |

## Verification
A wrong measurement counter or wait state shows up on err_value and err_valid on the clock that follows the closing edge, or as a false or absent edge_missing DIV_RATIO-1 cycles after a lone edge. A wrong hysteresis state shows on narrow_bw one clock after err_valid. A wrong offset sum or wrap appears on fb_phase_ofs on that same clock. A reload that should have been blocked appears on fb_phase_ofs at the next large measurement taken while narrow. The bench compares every output on every clock, so each such fault is reported within one cycle of its first visible effect.

// File: rtl/psm_pkg.sv
package psm_pkg;
  // Which edge the measurement is waiting for after its first edge.
  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_FB  = 2'd1,
    MS_WAIT_REF = 2'd2
  } psm_state_e;
endpackage

// File: rtl/psm_phase_meas.sv
module psm_phase_meas
  import psm_pkg::*;
#(
  parameter int DIV_RATIO = 64,
  localparam int CW = $clog2(DIV_RATIO),
  localparam int EW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_edge,
  input  logic                 fb_edge,
  output logic signed [EW-1:0] err_q,
  output logic                 err_vld_q,
  output logic                 miss_q
);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV_RATIO - 1);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  psm_state_e          st_q, st_n;
  logic [CW-1:0]       cnt_q, cnt_n;
  logic                vld_c, miss_c;
  logic signed [EW-1:0] err_c;

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    vld_c  = 1'b0;
    miss_c = 1'b0;
    err_c  = '0;
    unique case (st_q)
      MS_IDLE: begin
        if (ref_edge && fb_edge) begin
          vld_c = 1'b1;
        end else if (ref_edge) begin
          st_n  = MS_WAIT_FB;
          cnt_n = CNT_ONE;
        end else if (fb_edge) begin
          st_n  = MS_WAIT_REF;
          cnt_n = CNT_ONE;
        end
      end
      MS_WAIT_FB: begin
        if (fb_edge) begin
          vld_c = 1'b1;
          err_c = $signed({1'b0, cnt_q});
          st_n  = MS_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          miss_c = 1'b1;
          st_n   = MS_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      MS_WAIT_REF: begin
        if (ref_edge) begin
          vld_c = 1'b1;
          err_c = -$signed({1'b0, cnt_q});
          st_n  = MS_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          miss_c = 1'b1;
          st_n   = MS_IDLE;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: st_n = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= MS_IDLE;
      cnt_q     <= '0;
      err_q     <= '0;
      err_vld_q <= 1'b0;
      miss_q    <= 1'b0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      err_vld_q <= vld_c;
      if (vld_c) err_q <= err_c;
      if (miss_c)     miss_q <= 1'b1;
      else if (vld_c) miss_q <= 1'b0;
    end
  end

  AST_MISS_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_q) |-> (!err_vld_q && $stable(err_q))); // R9
  AST_MISS_CLEARED_BY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(miss_q) |-> err_vld_q); // R9
  AST_ERR_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> err_vld_q); // R2
endmodule

// File: rtl/psm_bw_ctrl.sv
module psm_bw_ctrl #(
  parameter int DIV_RATIO = 64,
  parameter int TRIG_THR  = 4,
  parameter int REL_THR   = 2,
  localparam int CW = $clog2(DIV_RATIO),
  localparam int EW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [EW-1:0] err,
  input  logic                 err_vld,
  input  logic                 apc_en,
  output logic                 narrow_q,
  output logic [CW-1:0]        ofs_q
);
  localparam int SW = EW + 1;
  localparam logic signed [SW-1:0] DIV_S  = SW'(DIV_RATIO);
  localparam logic [EW-1:0]        TRIG_U = EW'(TRIG_THR);
  localparam logic [EW-1:0]        REL_U  = EW'(REL_THR);

  logic [EW-1:0]        mag;
  logic signed [SW-1:0] sum, wrap;
  logic                 narrow_n;
  logic [CW-1:0]        ofs_n;

  always_comb begin
    mag = err[EW-1] ? EW'(-err) : EW'(err);
    sum = $signed({2'b00, ofs_q}) + $signed({err[EW-1], err});
    if (sum < 0)           wrap = sum + DIV_S;
    else if (sum >= DIV_S) wrap = sum - DIV_S;
    else                   wrap = sum;
  end

  always_comb begin
    narrow_n = narrow_q;
    ofs_n    = ofs_q;
    if (err_vld) begin
      if (!narrow_q && (mag > TRIG_U)) begin
        narrow_n = 1'b1;
        if (apc_en) ofs_n = wrap[CW-1:0];
      end else if (narrow_q && (mag <= REL_U)) begin
        narrow_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_q <= 1'b0;
      ofs_q    <= '0;
    end else begin
      narrow_q <= narrow_n;
      ofs_q    <= ofs_n;
    end
  end

  AST_ENTER_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(narrow_q) |-> $past(err_vld && (mag > TRIG_U))); // R3
  AST_EXIT_NEEDS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(narrow_q) |-> $past(err_vld && (mag <= REL_U))); // R5
  AST_OFS_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ofs_q) |-> $rose(narrow_q)); // R8
  AST_OFS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(apc_en) |-> $stable(ofs_q)); // R6
endmodule

// File: rtl/phase_step_monitor.sv
module phase_step_monitor #(
  parameter int DIV_RATIO = 64,
  parameter int TRIG_THR  = 4,
  parameter int REL_THR   = 2,
  localparam int CW = $clog2(DIV_RATIO),
  localparam int EW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_edge,
  input  logic          fb_edge,
  input  logic          reselect_en,
  output logic          narrow_bw,
  output logic [CW-1:0] fb_phase_ofs,
  output logic [EW-1:0] err_value,
  output logic          err_valid,
  output logic          edge_missing
);
  logic                 rst_meta_q, rst_sync_q;
  logic signed [EW-1:0] err_s;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  psm_phase_meas #(.DIV_RATIO(DIV_RATIO)) u_meas (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .err_q    (err_s),
    .err_vld_q(err_valid),
    .miss_q   (edge_missing)
  );

  psm_bw_ctrl #(
    .DIV_RATIO(DIV_RATIO),
    .TRIG_THR (TRIG_THR),
    .REL_THR  (REL_THR)
  ) u_bw (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .err     (err_s),
    .err_vld (err_valid),
    .apc_en  (reselect_en),
    .narrow_q(narrow_bw),
    .ofs_q   (fb_phase_ofs)
  );

  assign err_value = err_s;

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_sync_q |=> (!narrow_bw && !err_valid && !edge_missing)); // R1
endmodule

// File: tb/tb_phase_step_monitor.sv
`timescale 1ns/1ps
module tb_phase_step_monitor;
  localparam int DIV   = 64;
  localparam int TRIG  = 4;
  localparam int REL   = 2;
  localparam int CW    = $clog2(DIV);
  localparam int EW    = CW + 1;
  localparam int SPACE = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_e = 1'b0, fb_e = 1'b0, apc = 1'b0;
  logic          narrow_bw, err_valid, edge_missing;
  logic [CW-1:0] fb_phase_ofs;
  logic [EW-1:0] err_value;

  int n_tests = 0, n_fail = 0;
  bit chk_on = 0;

  // behavioural model state
  int pend = 0, t0 = 0, cyc = 0;
  int e_err = 0, e_ofs = 0;
  bit e_vld = 0, e_miss = 0, e_nar = 0;

  always #2 clk = ~clk;

  phase_step_monitor #(.DIV_RATIO(DIV), .TRIG_THR(TRIG), .REL_THR(REL)) dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_e), .fb_edge(fb_e),
    .reselect_en(apc), .narrow_bw(narrow_bw), .fb_phase_ofs(fb_phase_ofs),
    .err_value(err_value), .err_valid(err_valid), .edge_missing(edge_missing)
  );

  function automatic int sext(input logic [EW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic cmp(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Reference model: timestamps instead of a counter, one stage of delay for the controller.
  always @(posedge clk) begin
    if (!rst_n) begin
      pend = 0; e_err = 0; e_ofs = 0; e_vld = 0; e_miss = 0; e_nar = 0;
    end else begin
      int mag, d, ne;
      bit nv;
      if (e_vld) begin
        mag = (e_err < 0) ? -e_err : e_err;
        if (!e_nar && mag > TRIG) begin
          e_nar = 1;
          if (apc) e_ofs = (((e_ofs + e_err) % DIV) + DIV) % DIV;
        end else if (e_nar && mag <= REL) begin
          e_nar = 0;
        end
      end
      nv = 0; ne = 0;
      if (pend == 0) begin
        if (ref_e && fb_e) nv = 1;
        else if (ref_e) begin pend = 1; t0 = cyc; end
        else if (fb_e) begin pend = 2; t0 = cyc; end
      end else begin
        d = cyc - t0;
        if (pend == 1 && fb_e) begin nv = 1; ne = d; pend = 0; end
        else if (pend == 2 && ref_e) begin nv = 1; ne = -d; pend = 0; end
        else if (d == DIV - 1) begin e_miss = 1; pend = 0; end
      end
      e_vld = nv;
      if (nv) begin e_err = ne; e_miss = 0; end
    end
    cyc++;
  end

  always @(posedge clk) begin
    #1;
    if (chk_on) begin
      cmp("R2 err_valid", int'(err_valid), int'(e_vld));
      cmp("R2 err_value", sext(err_value), e_err);
      cmp("R3/R5 narrow_bw", int'(narrow_bw), int'(e_nar));
      cmp("R7 fb_phase_ofs", int'(fb_phase_ofs), e_ofs);
      cmp("R9 edge_missing", int'(edge_missing), int'(e_miss));
    end
  end

  // k > 0: reference first; k < 0: feedback first.
  task automatic pair(input int k);
    int a = (k >= 0) ? 0 : -k;
    int b = (k >= 0) ? k : 0;
    for (int i = 0; i < SPACE; i++) begin
      @(negedge clk);
      ref_e = (i == a);
      fb_e  = (i == b);
    end
  endtask

  task automatic lone(input bit is_ref);
    for (int i = 0; i < SPACE; i++) begin
      @(negedge clk);
      ref_e = is_ref && (i == 0);
      fb_e  = !is_ref && (i == 0);
    end
  endtask

  task automatic snap(input string req, input int nar, input int ofs, input int err, input int miss);
    cmp({req, " narrow"}, int'(narrow_bw), nar);
    cmp({req, " offset"}, int'(fb_phase_ofs), ofs);
    cmp({req, " error"}, sext(err_value), err);
    cmp({req, " missing"}, int'(edge_missing), miss);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    snap("R1 in reset", 0, 0, 0, 0);
    cmp("R1 valid in reset", int'(err_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    snap("R1 after reset", 0, 0, 0, 0);
    chk_on = 1;
    pair(1);   snap("R2 R4 ref leads by 1", 0, 0, 1, 0);
    pair(-1);  snap("R2 R4 fb leads by 1", 0, 0, -1, 0);
    pair(0);   snap("R2 same cycle", 0, 0, 0, 0);
    pair(4);   snap("R4 at trigger level", 0, 0, 4, 0);
    apc = 1'b0;
    pair(6);   snap("R3 R6 step without reselect", 1, 0, 6, 0);
    pair(3);   snap("R5 residual holds narrow", 1, 0, 3, 0);
    pair(-2);  snap("R5 release at level", 0, 0, -2, 0);
    apc = 1'b1;
    pair(-7);  snap("R7 reselect negative", 1, 57, -7, 0);
    pair(9);   snap("R8 no reload while narrow", 1, 57, 9, 0);
    pair(3);   snap("R5 residual after reselect", 1, 57, 3, 0);
    pair(1);   snap("R5 settle", 0, 57, 1, 0);
    pair(10);  snap("R7 wrap positive", 1, 3, 10, 0);
    pair(0);   snap("R5 release", 0, 3, 0, 0);
    lone(1);   snap("R9 lone reference", 0, 3, 0, 1);
    pair(2);   snap("R9 cleared by result", 0, 3, 2, 0);
    lone(0);   snap("R9 lone feedback", 0, 3, 2, 1);
    pair(63);  snap("R2 R7 partner at last cycle", 1, 2, 63, 0);
    pair(-1);  snap("R5 final release", 0, 2, -1, 0);
    apc = 1'b0;
    pair(-5);  snap("R3 R6 negative step", 1, 2, -5, 0);
    pair(-4);  snap("R5 above release level", 1, 2, -4, 0);
    pair(2);   snap("R5 release positive", 0, 2, 2, 0);
    chk_on = 0;
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule